// File: doc/BRIEF.md
# Multi-Mode Serial Audio Receiver

This block takes a two-channel serial audio stream whose bit clock, left/right clock and word clock all come from outside the chip. It turns that stream into one parallel word per channel, each with a single-cycle valid strobe. Every input is brought into the system clock domain through a synchronizer and edge-detected there. The serial clocks therefore drive no flop directly. A bit clock that stops, pauses or arrives in bursts is handled like a continuous one.

Four framing formats can be selected:
- left-justified, with the first bit on the first sampling edge after a left/right change;
- left-justified, with the first bit one edge later;
- right-justified, with the first bit 16 bit periods after the left/right change;
- word-clock started, where a rising word-clock edge begins a word and the left/right level only names the channel.

A polarity input selects the bit-clock edge on which data is sampled. The word length can be set from 4 to 16 bits. Each word is delivered MSB-aligned in a 16-bit output, so the sign bit stays at the top.

Top module: `serial_audio_rx`

## Requirements
- R1: After a synchronous reset, both valid outputs are low and both data outputs are zero.
- R2: A word received while the left/right level is high appears on the left outputs. A word received while it is low appears on the right outputs. In the word-clock format, the channel is the left/right level at the word-clock rising edge. At most one valid output is high in any cycle.
- R3: With `smp_fall_i` low, data is sampled on rising bit-clock edges. With it high, data is sampled on falling bit-clock edges.
- R4: Format code 0 captures the N data bits, MSB first, on sampling edges 1 to N after each left/right transition.
- R5: Format code 1 captures them on sampling edges 2 to N+1 after each left/right transition.
- R6: Format code 2 captures them on sampling edges 17 to 16+N after each left/right transition.
- R7: Format code 3 captures them on sampling edges 1 to N counted from a rising edge of `wclk_i`. Left/right transitions do not restart a word in this format, and the word clock is ignored in the other formats.
- R8: The effective length N is `word_len_i` limited to the range 4 to 16. The N bits are placed in bits 15 down to 16-N of the output, and the bits below are zero.
- R9: `fmt_i` and `word_len_i` are taken only at reset and at each rising left/right transition. Both channels of that frame use these values, and changes at other times have no effect.
- R10: Each word produces exactly one single-cycle valid pulse after its last bit. Line values on sampling edges outside the capture window do not affect any output.
- R11: Pauses of any length in the bit clock between edges do not change the received words.
- R12: Bit, left/right and word clocks pass through two synchronizing flops. Correct reception requires a bit-clock period longer than four system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | External serial bit clock |
| lrck_i | input | 1 | External left/right clock, high = left |
| wclk_i | input | 1 | External word clock (format 3 only) |
| sdata_i | input | 1 | Serial data, MSB first, twos complement |
| smp_fall_i | input | 1 | 0: sample on rising bit-clock edge, 1: on falling edge |
| fmt_i | input | 2 | Framing format code 0 to 3 |
| word_len_i | input | 5 | Bits per channel, effective range 4 to 16 |
| left_data_o | output | 16 | Last left word, MSB-aligned |
| left_valid_o | output | 1 | One-cycle strobe for a new left word |
| right_data_o | output | 16 | Last right word, MSB-aligned |
| right_valid_o | output | 1 | One-cycle strobe for a new right word |

## Verification
On every cycle the assertions check the following:
- the two valid strobes never coincide, and each strobe lasts one cycle and follows a final captured bit;
- the unused low bits of a delivered word are zero, and the latched length stays within 4 to 16;
- the frame configuration changes only at a rising left/right transition;
- bit-clock edges are spaced as the rate limit requires.

Only the bench scenarios can show that the right bits land in the right channel for each format and sampling edge. The same holds for the right-justified offset, the word clock starting a word late in its slot, and the clamping of out-of-range lengths. Likewise for a length change made mid-frame, bursty bit clocks, and random filler bits outside the capture window.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ     = 2'd0,
    FMT_LJ_DLY = 2'd1,
    FMT_RJ     = 2'd2,
    FMT_WCLK   = 2'd3
  } rx_fmt_e;

  localparam logic CH_LEFT = 1'b1;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sarx_frame_ctrl.sv
module sarx_frame_ctrl
  import sarx_pkg::*;
#(
  parameter int MAX_BITS  = 16,
  parameter int MIN_BITS  = 4,
  parameter int RJ_OFFSET = 16,
  parameter int LEN_W     = 5,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_edge_i,
  input  logic             lr_lvl_i,
  input  logic             lr_rise_i,
  input  logic             lr_fall_i,
  input  logic             wclk_rise_i,
  input  logic [1:0]       fmt_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             cap_o,
  output logic             last_o,
  output logic             chan_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    logic [LEN_W-1:0] r;
    if (v < LEN_W'(MIN_BITS))      r = LEN_W'(MIN_BITS);
    else if (v > LEN_W'(MAX_BITS)) r = LEN_W'(MAX_BITS);
    else                           r = v;
    return r;
  endfunction

  rx_fmt_e          fmt_q, fmt_n;
  logic [LEN_W-1:0] len_q, len_n;
  logic [CNT_W-1:0] cnt_q, pos_n, inc_n, first_n, end_n;
  logic             chan_q, chan_n, evt;

  // frame configuration is refreshed only when a new left word begins
  assign fmt_n = lr_rise_i ? rx_fmt_e'(fmt_i) : fmt_q;
  assign len_n = lr_rise_i ? clamp_len(len_i) : len_q;

  assign evt = (fmt_n == FMT_WCLK) ? wclk_rise_i : (lr_rise_i | lr_fall_i);

  assign inc_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);

  always_comb begin
    if (evt)             pos_n = smp_edge_i ? CNT_W'(1) : '0;
    else if (smp_edge_i) pos_n = inc_n;
    else                 pos_n = cnt_q;
  end

  always_comb begin
    case (fmt_n)
      FMT_LJ_DLY: first_n = CNT_W'(2);
      FMT_RJ:     first_n = CNT_W'(RJ_OFFSET + 1);
      default:    first_n = CNT_W'(1);
    endcase
  end

  assign end_n  = first_n + CNT_W'(len_n) - CNT_W'(1);
  assign chan_n = evt ? lr_lvl_i : chan_q;

  assign cap_o  = smp_edge_i && (pos_n >= first_n) && (pos_n <= end_n);
  assign last_o = smp_edge_i && (pos_n == end_n);
  assign chan_o = chan_n;
  assign len_o  = len_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= rx_fmt_e'(fmt_i);
      len_q  <= clamp_len(len_i);
      cnt_q  <= '0;
      chan_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_n;
      len_q  <= len_n;
      cnt_q  <= pos_n;
      chan_q <= chan_n;
    end
  end

  // R8: latched length always inside the legal window
  assert_len_range_R8: assert property (@(posedge clk) disable iff (rst)
    (len_q >= LEN_W'(MIN_BITS)) && (len_q <= LEN_W'(MAX_BITS)));

  // R9: configuration only moves at a rising left/right transition
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !lr_rise_i |=> ($stable(fmt_q) && $stable(len_q)));

  // R10: the word-complete strobe lies inside the capture window
  assert_last_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    last_o |-> cap_o);
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_i,
  input  logic                last_i,
  input  logic                chan_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                din_i,
  output logic [MAX_BITS-1:0] left_data_o,
  output logic                left_valid_o,
  output logic [MAX_BITS-1:0] right_data_o,
  output logic                right_valid_o
);
  localparam logic [LEN_W-1:0]    MAXL = LEN_W'(MAX_BITS);
  localparam logic [MAX_BITS-1:0] ONES = '1;

  logic [MAX_BITS-1:0] shreg_q, shift_n, word_n;

  assign shift_n = {shreg_q[MAX_BITS-2:0], din_i};
  assign word_n  = shift_n << (MAXL - len_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q       <= '0;
      left_data_o   <= '0;
      right_data_o  <= '0;
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
    end else begin
      left_valid_o  <= 1'b0;
      right_valid_o <= 1'b0;
      if (cap_i) shreg_q <= shift_n;
      if (last_i) begin
        if (chan_i == CH_LEFT) begin
          left_data_o  <= word_n;
          left_valid_o <= 1'b1;
        end else begin
          right_data_o  <= word_n;
          right_valid_o <= 1'b1;
        end
      end
    end
  end

  // R2: one channel per delivered word
  assert_one_channel_R2: assert property (@(posedge clk) disable iff (rst)
    !(left_valid_o && right_valid_o));

  // R10: strobes are single-cycle
  assert_left_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    left_valid_o |=> !left_valid_o);
  assert_right_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    right_valid_o |=> !right_valid_o);

  // R8: bits below the received word are zero
  assert_left_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    left_valid_o |-> ((left_data_o & ~(ONES << (MAXL - $past(len_i)))) == '0));
  assert_right_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    right_valid_o |-> ((right_data_o & ~(ONES << (MAXL - $past(len_i)))) == '0));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int MAX_BITS    = 16,
  parameter int MIN_BITS    = 4,
  parameter int RJ_OFFSET   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bclk_i,
  input  logic                           lrck_i,
  input  logic                           wclk_i,
  input  logic                           sdata_i,
  input  logic                           smp_fall_i,
  input  logic [1:0]                     fmt_i,
  input  logic [$clog2(MAX_BITS+1)-1:0]  word_len_i,
  output logic [MAX_BITS-1:0]            left_data_o,
  output logic                           left_valid_o,
  output logic [MAX_BITS-1:0]            right_data_o,
  output logic                           right_valid_o
);
  localparam int LEN_W = $clog2(MAX_BITS + 1);
  localparam int CNT_W = $clog2(RJ_OFFSET + MAX_BITS + 2);
  localparam int IDX_BCLK = 0;
  localparam int IDX_LR   = 1;
  localparam int IDX_WCLK = 2;
  localparam int IDX_DATA = 3;

  logic [3:0]       sync_lvl;
  logic [2:0]       prev_q;
  logic             bclk_rise, bclk_fall, lr_rise, lr_fall, wclk_rise, smp_edge;
  logic             cap, last, chan;
  logic [LEN_W-1:0] len_cur;

  sarx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdata_i, wclk_i, lrck_i, bclk_i}),
    .q_o (sync_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_lvl[2:0];
  end

  assign bclk_rise = sync_lvl[IDX_BCLK] & ~prev_q[IDX_BCLK];
  assign bclk_fall = ~sync_lvl[IDX_BCLK] & prev_q[IDX_BCLK];
  assign lr_rise   = sync_lvl[IDX_LR] & ~prev_q[IDX_LR];
  assign lr_fall   = ~sync_lvl[IDX_LR] & prev_q[IDX_LR];
  assign wclk_rise = sync_lvl[IDX_WCLK] & ~prev_q[IDX_WCLK];
  assign smp_edge  = smp_fall_i ? bclk_fall : bclk_rise;

  sarx_frame_ctrl #(
    .MAX_BITS (MAX_BITS),
    .MIN_BITS (MIN_BITS),
    .RJ_OFFSET(RJ_OFFSET),
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .smp_edge_i (smp_edge),
    .lr_lvl_i   (sync_lvl[IDX_LR]),
    .lr_rise_i  (lr_rise),
    .lr_fall_i  (lr_fall),
    .wclk_rise_i(wclk_rise),
    .fmt_i      (fmt_i),
    .len_i      (word_len_i),
    .cap_o      (cap),
    .last_o     (last),
    .chan_o     (chan),
    .len_o      (len_cur)
  );

  sarx_deser #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_deser (
    .clk          (clk),
    .rst          (rst),
    .cap_i        (cap),
    .last_i       (last),
    .chan_i       (chan),
    .len_i        (len_cur),
    .din_i        (sync_lvl[IDX_DATA]),
    .left_data_o  (left_data_o),
    .left_valid_o (left_valid_o),
    .right_data_o (right_data_o),
    .right_valid_o(right_valid_o)
  );

  // R12: synchronized bit-clock edges never fall on consecutive cycles
  assert_bclk_slow_R12: assert property (@(posedge clk) disable iff (rst)
    (bclk_rise || bclk_fall) |=> !(bclk_rise || bclk_fall));
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, lrck = 1'b0, wclk = 1'b0, sdata = 1'b0, pol = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic [4:0]  wlen = 5'd16;
  logic [15:0] left_data, right_data;
  logic        left_valid, right_valid;

  int          checks = 0, fails = 0, cyc = 0;
  int          half = 4;
  bit          burst = 1'b0;
  string       cur_req = "R4";
  logic [15:0] exp_l[$], exp_r[$];

  always #2 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .lrck_i(lrck), .wclk_i(wclk),
    .sdata_i(sdata), .smp_fall_i(pol), .fmt_i(fmt), .word_len_i(wlen),
    .left_data_o(left_data), .left_valid_o(left_valid),
    .right_data_o(right_data), .right_valid_o(right_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(input int n);
    if (n < 4) return 4;
    if (n > 16) return 16;
    return n;
  endfunction

  // reference model: compare each strobe against the next expected word
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (left_valid) begin
        if (exp_l.size() == 0) check("R2", 32'd1, 32'd0, "unexpected left strobe");
        else check(cur_req, 32'(left_data), 32'(exp_l.pop_front()), "left word");
      end
      if (right_valid) begin
        if (exp_r.size() == 0) check("R2", 32'd1, 32'd0, "unexpected right strobe");
        else check(cur_req, 32'(right_data), 32'(exp_r.pop_front()), "right word");
      end
    end
    if (cyc == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic bit_period(input logic b, input bit set_lr, input logic lr_v,
                            input bit set_w, input logic w_v);
    if (burst) repeat ($urandom_range(0, 12)) @(negedge clk);
    bclk = pol;
    sdata = b;
    if (set_lr) lrck = lr_v;
    if (set_w) wclk = w_v;
    repeat (half) @(negedge clk);
    bclk = ~pol;
    repeat (half) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr_v, input int mode, input int n,
                           input logic [15:0] val, input int wdly, input int chg_len);
    int first;
    first = (mode == 0) ? 1 : (mode == 1) ? 2 : (mode == 2) ? 17 : 1 + wdly;
    for (int k = 1; k <= 32; k++) begin
      logic b;
      bit sw;
      logic wv;
      b = 1'($urandom_range(0, 1));
      if (k >= first && k < first + n) b = val[n - 1 - (k - first)];
      sw = 1'b0; wv = 1'b0;
      if (mode == 3) begin
        if (k == 1 + wdly)     begin sw = 1'b1; wv = 1'b1; end
        if (k == 3 + wdly)     begin sw = 1'b1; wv = 1'b0; end
      end else begin
        if (k == 5)            begin sw = 1'b1; wv = 1'b1; end
        if (k == 9)            begin sw = 1'b1; wv = 1'b0; end
      end
      if (chg_len != 0 && k == 8) wlen = 5'(chg_len);
      bit_period(b, k == 1, lr_v, sw, wv);
    end
  endtask

  task automatic send_frame(input int mode, input int len_prog, input logic [15:0] lv,
                            input logic [15:0] rv, input int wdly, input int chg_len);
    int n;
    n = eff_len(len_prog);
    fmt = 2'(mode);
    wlen = 5'(len_prog);
    exp_l.push_back(16'((32'(lv) & ((32'd1 << n) - 1)) << (16 - n)));
    exp_r.push_back(16'((32'(rv) & ((32'd1 << n) - 1)) << (16 - n)));
    send_slot(1'b1, mode, n, lv, wdly, chg_len);
    send_slot(1'b0, mode, n, rv, wdly, 0);
  endtask

  task automatic drain(input string req);
    repeat (40) @(negedge clk);
    check(req, 32'(exp_l.size() + exp_r.size()), 32'd0, "words still pending");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", 32'(left_valid), 32'd0, "left valid in reset");
    check("R1", 32'(right_valid), 32'd0, "right valid in reset");
    check("R1", 32'(left_data), 32'd0, "left data in reset");
    check("R1", 32'(right_data), 32'd0, "right data in reset");
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1", 32'(left_valid | right_valid), 32'd0, "valid after reset");

    cur_req = "R4";
    send_frame(0, 16, 16'hA5C3, 16'h1234, 0, 0);
    send_frame(0, 4, 16'h0009, 16'h0006, 0, 0);
    drain("R10");

    cur_req = "R2";
    send_frame(0, 16, 16'h8001, 16'h7FFE, 0, 0);
    send_frame(3, 16, 16'hF00D, 16'h0BAD, 0, 0);
    drain("R2");

    cur_req = "R5";
    send_frame(1, 16, 16'hC0DE, 16'h5AA5, 0, 0);
    send_frame(1, 12, 16'h0ABC, 16'h0F0F, 0, 0);
    drain("R5");

    cur_req = "R6";
    send_frame(2, 16, 16'hBEEF, 16'h4321, 0, 0);
    send_frame(2, 8, 16'h00E7, 16'h0018, 0, 0);
    drain("R6");

    cur_req = "R7";
    send_frame(3, 16, 16'h9876, 16'h2468, 0, 0);
    send_frame(3, 10, 16'h02A5, 16'h015A, 3, 0);
    drain("R7");

    cur_req = "R3";
    pol = 1'b1;
    repeat (10) @(negedge clk);
    send_frame(0, 16, 16'h3C3C, 16'hC3C3, 0, 0);
    send_frame(1, 14, 16'h2BCD, 16'h1357, 0, 0);
    send_frame(2, 16, 16'h7F00, 16'h80FF, 0, 0);
    drain("R3");
    pol = 1'b0;
    repeat (10) @(negedge clk);

    cur_req = "R8";
    send_frame(0, 2, 16'h000B, 16'h0004, 0, 0);
    send_frame(0, 20, 16'hE1E1, 16'h1E1E, 0, 0);
    send_frame(1, 7, 16'h0055, 16'h002A, 0, 0);
    drain("R8");

    cur_req = "R9";
    send_frame(0, 8, 16'h00C5, 16'h003A, 0, 16);
    send_frame(0, 16, 16'hD00D, 16'h0F0E, 0, 0);
    drain("R9");

    cur_req = "R11";
    burst = 1'b1;
    send_frame(0, 16, 16'h6EED, 16'h9112, 0, 0);
    send_frame(2, 12, 16'h0777, 16'h0888, 0, 0);
    send_frame(3, 16, 16'hABCD, 16'h5432, 2, 0);
    drain("R11");
    burst = 1'b0;

    cur_req = "R12";
    half = 3;
    send_frame(0, 16, 16'h1F2E, 16'hE2F1, 0, 0);
    send_frame(2, 16, 16'h4C4C, 16'hB3B3, 0, 0);
    drain("R12");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule